// File: doc/BRIEF.md
# DMA Stream Address and Count Sequencer

This block is the per-stream engine of a DMA channel. Software or a controller hands it a source address, a destination address, a unit count, a width for each side, a burst length and a fixed-or-increment choice for each side, and pulses `start`. The block checks the setup, refuses bad setups with an error flag, and otherwise arms itself. Each time the arbiter grants it a burst, it issues a run of read beats followed by a run of write beats. It advances each address by that side's access size when incrementing is chosen, and takes the burst's units off the remaining count.

A unit is one source-width item. A burst carries up to the selected burst length in units, and the final burst carries whatever is left. The number of write beats in a burst is the burst's byte total divided by the destination size. After the last write of every burst, `burst_end` pulses for one clock. After the last write of the whole transfer, `done` pulses as well, and `busy` drops in that same cycle.

The machine has four states. S_IDLE means disabled. S_ARMED means enabled and waiting for a grant. S_READ issues read beats, and S_WRITE issues write beats. The transitions are as follows:
- S_IDLE goes to S_ARMED on an accepted start.
- S_ARMED goes to S_READ on grant.
- S_READ goes to S_WRITE after its last read beat.
- S_WRITE goes back to S_ARMED after its last write beat if units remain.
- S_WRITE goes to S_IDLE after its last write beat if no units remain.

Top module: `dma_stream_seq`

## Requirements
- R1: After reset, `busy`, `rd_valid`, `wr_valid`, `done`, `burst_end`, `err_cfg` and `err_align` are all 0. A `start` in S_IDLE with a legal setup raises `busy` on the next clock. A `start` while `busy` is high is ignored, and the running transfer continues unchanged.
- R2: A `start` in S_IDLE sets `err_cfg` and leaves `busy` low if any of these holds: the count is zero; either width code is 3; `cfg_byte_port` is 1 and either width is not byte; or the destination is wider than the source and either the total byte count or a full burst's byte count is not a multiple of the destination size. Width codes are 0 for byte, 1 for halfword and 2 for word.
- R3: A `start` in S_IDLE whose source or destination address is not a multiple of that side's size sets `err_align` and leaves `busy` low. Both error flags hold until the next start that is taken in S_IDLE.
- R4: Burst code 0, 1, 2 and 3 select 1, 4, 8 and 16 units respectively. When fewer units remain than the burst length, the burst carries only the remaining units.
- R5: After a grant in S_ARMED, `rd_valid` is high from the next clock for exactly as many cycles as the burst has units. `wr_valid` is then high for (units × source bytes) / destination bytes cycles.
- R6: An incrementing address grows by 1, 2 or 4 after each of its side's beats, according to that side's width. A fixed address keeps its start value. `rd_width` and `wr_width` carry the widths latched at start.
- R7: The total number of read beats over a transfer equals the programmed count.
- R8: `burst_end` is high for exactly one clock after the last write beat of every burst. `grant` has no effect unless the block is in S_ARMED.
- R9: `done` is high for exactly one clock, after the final write beat of the transfer, and `busy` is low in that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load the setup and try to enable the stream |
| cfg_src_addr | input | AW | Source start address |
| cfg_dst_addr | input | AW | Destination start address |
| cfg_count | input | CW | Number of source units to move |
| cfg_src_width | input | 2 | Source width code (0 byte, 1 half, 2 word) |
| cfg_dst_width | input | 2 | Destination width code (0 byte, 1 half, 2 word) |
| cfg_burst | input | 2 | Burst code (0:1, 1:4, 2:8, 3:16 units) |
| cfg_src_incr | input | 1 | 1 increments the source address, 0 keeps it fixed |
| cfg_dst_incr | input | 1 | 1 increments the destination address, 0 keeps it fixed |
| cfg_byte_port | input | 1 | Peripheral side accepts bytes only |
| grant | input | 1 | Burst granted by the arbiter |
| rd_valid | output | 1 | Read beat issued this cycle |
| rd_addr | output | AW | Read beat address |
| rd_width | output | 2 | Read beat width code |
| wr_valid | output | 1 | Write beat issued this cycle |
| wr_addr | output | AW | Write beat address |
| wr_width | output | 2 | Write beat width code |
| burst_end | output | 1 | One-clock pulse after a burst's last write |
| done | output | 1 | One-clock pulse after the transfer's last write |
| busy | output | 1 | Stream enabled |
| err_cfg | output | 1 | Last start refused for an illegal setup |
| err_align | output | 1 | Last start refused for a misaligned address |

## Verification
The main function is tried with a range of setups:
- Equal widths with single-unit bursts, which gives one burst per unit.
- Narrow-to-wide and wide-to-narrow width pairs, which separate the read beat count from the write beat count.
- Counts that are not multiples of the burst length, which expose the shortened final burst.
- Every mix of fixed and incrementing addresses, which shows that each side's stepping is independent.

Every read and write address is compared beat by beat against an address computed in the bench. One run injects a start with a zero count in mid-transfer, which separates a correctly ignored start from one that reloads the stream or raises an error. Directed cases cover each cause of refusal on its own, and a grant given while the block is disabled.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ARMED = 2'd1,
        S_READ  = 2'd2,
        S_WRITE = 2'd3
    } seq_state_e;

    localparam int unsigned MAX_BURST = 16;
    localparam int unsigned BEAT_W    = 7;   // up to 16 units x 4 bytes / 1 byte = 64 beats

    // burst code -> units per burst
    function automatic logic [4:0] burst_units(input logic [1:0] code);
        logic [4:0] u;
        unique case (code)
            2'd0: u = 5'd1;
            2'd1: u = 5'd4;
            2'd2: u = 5'd8;
            default: u = 5'd16;
        endcase
        return u;
    endfunction

    // low address bits that must be zero for a width code
    function automatic logic [1:0] size_mask(input logic [1:0] w);
        logic [1:0] m;
        unique case (w)
            2'd0: m = 2'b00;
            2'd1: m = 2'b01;
            default: m = 2'b11;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dma_seq_check.sv
module dma_seq_check
    import dma_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    input  logic [CW-1:0] count,
    input  logic [1:0]    src_w,
    input  logic [1:0]    dst_w,
    input  logic [1:0]    burst,
    input  logic          byte_port,
    output logic          cfg_bad,
    output logic          align_bad
);
    localparam int TW = CW + 2;

    logic [TW-1:0] total_bytes;
    logic [6:0]    full_bytes;
    logic [1:0]    dmask;
    logic [1:0]    smask;
    logic          pack_bad;

    always_comb begin
        smask       = size_mask(src_w);
        dmask       = size_mask(dst_w);
        total_bytes = TW'(count) << src_w;
        full_bytes  = 7'(burst_units(burst)) << src_w;
        // a wider destination needs whole destination items per burst and in total
        pack_bad    = ((total_bytes[1:0] & dmask) != 2'b00) ||
                      ((full_bytes[1:0]  & dmask) != 2'b00);
        cfg_bad     = (count == '0) || (src_w == 2'd3) || (dst_w == 2'd3) ||
                      (byte_port && (src_w != 2'd0 || dst_w != 2'd0)) || pack_bad;
        align_bad   = ((src_addr[1:0] & smask) != 2'b00) ||
                      ((dst_addr[1:0] & dmask) != 2'b00);
    end

endmodule

// File: rtl/dma_seq_addr.sv
module dma_seq_addr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          incr,
    input  logic [1:0]    width,
    input  logic          step,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] stride;

    always_comb stride = AW'(1) << width;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             addr <= '0;
        else if (load)          addr <= base;
        else if (step && incr)  addr <= addr + stride;
    end

    // fixed address, or no beat, leaves the pointer alone
    assert_fixed_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(step && incr)) |=> $stable(addr));

    // an incrementing beat always moves the pointer forward
    assert_step_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step && incr) |=> (addr != $past(addr)));

endmodule

// File: rtl/dma_seq_count.sv
module dma_seq_count
    import dma_seq_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] init,
    input  logic          take,
    input  logic [1:0]    burst,
    output logic [CW-1:0] remaining,
    output logic [4:0]    units
);
    logic [4:0] full;

    always_comb begin
        full = burst_units(burst);
        if (remaining < CW'(full)) units = remaining[4:0];
        else                       units = full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     remaining <= '0;
        else if (load)  remaining <= init;
        else if (take)  remaining <= remaining - CW'(units);
    end

    // the count only goes down between loads
    assert_count_monotonic_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (remaining <= $past(remaining)));

    // a taken burst is never empty and never longer than the maximum
    assert_burst_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (units != 5'd0 && units <= 5'(MAX_BURST)));

endmodule

// File: rtl/dma_stream_seq.sv
module dma_stream_seq
    import dma_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] cfg_src_addr,
    input  logic [AW-1:0] cfg_dst_addr,
    input  logic [CW-1:0] cfg_count,
    input  logic [1:0]    cfg_src_width,
    input  logic [1:0]    cfg_dst_width,
    input  logic [1:0]    cfg_burst,
    input  logic          cfg_src_incr,
    input  logic          cfg_dst_incr,
    input  logic          cfg_byte_port,
    input  logic          grant,
    output logic          rd_valid,
    output logic [AW-1:0] rd_addr,
    output logic [1:0]    rd_width,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [1:0]    wr_width,
    output logic          burst_end,
    output logic          done,
    output logic          busy,
    output logic          err_cfg,
    output logic          err_align
);
    seq_state_e          state, state_nx;
    logic [BEAT_W-1:0]   beats_left;
    logic [BEAT_W-1:0]   wr_beats_q;
    logic [BEAT_W-1:0]   wr_beats_nx;
    logic [1:0]          sw_q, dw_q, bl_q;
    logic                si_q, di_q;
    logic                done_q, bend_q;
    logic                cfg_bad, align_bad;
    logic                accept, take, last_beat;
    logic [CW-1:0]       remaining;
    logic [4:0]          units;

    dma_seq_check #(.AW(AW), .CW(CW)) u_check (
        .src_addr (cfg_src_addr),
        .dst_addr (cfg_dst_addr),
        .count    (cfg_count),
        .src_w    (cfg_src_width),
        .dst_w    (cfg_dst_width),
        .burst    (cfg_burst),
        .byte_port(cfg_byte_port),
        .cfg_bad  (cfg_bad),
        .align_bad(align_bad)
    );

    always_comb begin
        accept      = start && (state == S_IDLE) && !cfg_bad && !align_bad;
        take        = (state == S_ARMED) && grant;
        last_beat   = (beats_left == BEAT_W'(1));
        wr_beats_nx = (BEAT_W'(units) << sw_q) >> dw_q;
    end

    dma_seq_count #(.CW(CW)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .init     (cfg_count),
        .take     (take),
        .burst    (bl_q),
        .remaining(remaining),
        .units    (units)
    );

    dma_seq_addr #(.AW(AW)) u_src (
        .clk  (clk),
        .rst_n(rst_n),
        .load (accept),
        .base (cfg_src_addr),
        .incr (si_q),
        .width(sw_q),
        .step (state == S_READ),
        .addr (rd_addr)
    );

    dma_seq_addr #(.AW(AW)) u_dst (
        .clk  (clk),
        .rst_n(rst_n),
        .load (accept),
        .base (cfg_dst_addr),
        .incr (di_q),
        .width(dw_q),
        .step (state == S_WRITE),
        .addr (wr_addr)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (accept)    state_nx = S_ARMED;
            S_ARMED: if (grant)     state_nx = S_READ;
            S_READ:  if (last_beat) state_nx = S_WRITE;
            S_WRITE: if (last_beat) state_nx = (remaining == '0) ? S_IDLE : S_ARMED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // datapath registers owned by the state machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beats_left <= '0;
            wr_beats_q <= '0;
            sw_q       <= '0;
            dw_q       <= '0;
            bl_q       <= '0;
            si_q       <= 1'b0;
            di_q       <= 1'b0;
            done_q     <= 1'b0;
            bend_q     <= 1'b0;
            err_cfg    <= 1'b0;
            err_align  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            bend_q <= 1'b0;
            if (start && state == S_IDLE) begin
                err_cfg   <= cfg_bad;
                err_align <= align_bad;
            end
            if (accept) begin
                sw_q <= cfg_src_width;
                dw_q <= cfg_dst_width;
                bl_q <= cfg_burst;
                si_q <= cfg_src_incr;
                di_q <= cfg_dst_incr;
            end
            unique case (state)
                S_IDLE: ;
                S_ARMED: if (grant) begin
                    beats_left <= BEAT_W'(units);
                    wr_beats_q <= wr_beats_nx;
                end
                S_READ: begin
                    if (last_beat) beats_left <= wr_beats_q;
                    else           beats_left <= beats_left - BEAT_W'(1);
                end
                S_WRITE: begin
                    if (last_beat) begin
                        bend_q <= 1'b1;
                        done_q <= (remaining == '0);
                    end
                    beats_left <= beats_left - BEAT_W'(1);
                end
            endcase
        end
    end

    // output decode
    always_comb begin
        rd_valid  = (state == S_READ);
        wr_valid  = (state == S_WRITE);
        busy      = (state != S_IDLE);
        rd_width  = sw_q;
        wr_width  = dw_q;
        done      = done_q;
        burst_end = bend_q;
    end

    assert_rw_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && wr_valid));

    assert_grant_opens_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_valid && !wr_valid && grant) |=> rd_valid);

    assert_grant_ignored_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);

    assert_done_clears_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && burst_end));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_burst_end_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_end) |-> $past(wr_valid));

    // R3 as well: a refused start never enables the stream
    assert_refused_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (cfg_bad || align_bad)) |=> (!busy && (err_cfg || err_align)));

endmodule

// File: tb/dma_stream_seq_bench.sv
module dma_stream_seq_bench;
    localparam int AW = 32;
    localparam int CW = 16;

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic [15:0] cnt;
        logic [1:0]  sw;
        logic [1:0]  dw;
        logic [1:0]  bl;
        logic        si;
        logic        di;
        logic [15:0] nb;    // expected bursts
        logic        inj;   // inject a start mid-transfer
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VT [NV] = '{
        '{32'h0000_1000, 32'h0000_2000, 16'd5,  2'd0, 2'd0, 2'd0, 1'b1, 1'b1, 16'd5, 1'b0},
        '{32'h0000_0100, 32'h0000_0400, 16'd10, 2'd1, 2'd2, 2'd1, 1'b1, 1'b0, 16'd3, 1'b0},
        '{32'h0000_8000, 32'h0000_0010, 16'd3,  2'd2, 2'd0, 2'd3, 1'b0, 1'b1, 16'd1, 1'b0},
        '{32'h0000_0003, 32'h0000_0007, 16'd33, 2'd0, 2'd0, 2'd3, 1'b1, 1'b1, 16'd3, 1'b1},
        '{32'h0000_4000, 32'h0000_5000, 16'd17, 2'd2, 2'd2, 2'd2, 1'b0, 1'b1, 16'd3, 1'b0},
        '{32'h0000_0202, 32'h0000_0306, 16'd1,  2'd1, 2'd1, 2'd1, 1'b0, 1'b0, 16'd1, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] cfg_src_addr = '0;
    logic [AW-1:0] cfg_dst_addr = '0;
    logic [CW-1:0] cfg_count = '0;
    logic [1:0]    cfg_src_width = '0;
    logic [1:0]    cfg_dst_width = '0;
    logic [1:0]    cfg_burst = '0;
    logic          cfg_src_incr = 1'b0;
    logic          cfg_dst_incr = 1'b0;
    logic          cfg_byte_port = 1'b0;
    logic          grant = 1'b0;
    logic          rd_valid, wr_valid, burst_end, done, busy, err_cfg, err_align;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [1:0]    rd_width, wr_width;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dma_stream_seq #(.AW(AW), .CW(CW)) u_dma_stream_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
        .cfg_count(cfg_count), .cfg_src_width(cfg_src_width),
        .cfg_dst_width(cfg_dst_width), .cfg_burst(cfg_burst),
        .cfg_src_incr(cfg_src_incr), .cfg_dst_incr(cfg_dst_incr),
        .cfg_byte_port(cfg_byte_port), .grant(grant),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_width(rd_width),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_width(wr_width),
        .burst_end(burst_end), .done(done), .busy(busy),
        .err_cfg(err_cfg), .err_align(err_align)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [31:0] s, input logic [31:0] d, input logic [15:0] c,
                           input logic [1:0] sw, input logic [1:0] dw, input logic [1:0] bl,
                           input logic si, input logic di, input logic bp);
        cfg_src_addr = s; cfg_dst_addr = d; cfg_count = c;
        cfg_src_width = sw; cfg_dst_width = dw; cfg_burst = bl;
        cfg_src_incr = si; cfg_dst_incr = di; cfg_byte_port = bp;
    endtask

    function automatic int units_of(input logic [1:0] bl);
        return (bl == 2'd0) ? 1 : (bl == 2'd1) ? 4 : (bl == 2'd2) ? 8 : 16;
    endfunction

    task automatic run_vec(input vec_t v);
        int rd_n = 0, wr_n = 0, be_n = 0, done_n = 0;
        int cur_len = 0, last_len = 0, bad_addr = 0, bad_misc = 0;
        int tail = -1, cyc = 0, L, exp_last;
        logic [31:0] exp_a;
        bit injected = 1'b0;
        @(negedge clk);
        set_cfg(v.src, v.dst, v.cnt, v.sw, v.dw, v.bl, v.si, v.di, 1'b0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R1 busy after start", busy, 1);
        while (tail != 0 && cyc < 3000) begin
            cyc++;
            if (rd_valid) begin
                exp_a = v.src + (v.si ? (32'(rd_n) << v.sw) : 32'd0);
                if (rd_addr != exp_a || rd_width != v.sw) bad_addr++;
                rd_n++; cur_len++;
            end
            if (wr_valid) begin
                exp_a = v.dst + (v.di ? (32'(wr_n) << v.dw) : 32'd0);
                if (wr_addr != exp_a || wr_width != v.dw) bad_addr++;
                wr_n++;
            end
            if (burst_end) begin be_n++; last_len = cur_len; cur_len = 0; end
            if (done) begin done_n++; if (busy) bad_misc++; end
            if (err_cfg || err_align) bad_misc++;
            grant = busy && !rd_valid && !wr_valid;
            if (v.inj && rd_n == 2 && !injected) begin
                injected = 1'b1;
                start = 1'b1; cfg_count = '0; cfg_src_addr = 32'h1;
            end else begin
                start = 1'b0;
            end
            if (tail > 0) tail--;
            else if (tail < 0 && done) tail = 2;
            @(negedge clk);
        end
        grant = 1'b0; start = 1'b0;
        if (cyc >= 3000) chk("watchdog: transfer hung", 1, 0);
        L = units_of(v.bl);
        exp_last = (int'(v.cnt) % L == 0) ? L : int'(v.cnt) % L;
        chk("R7 total read beats", rd_n, v.cnt);
        chk("R5 total write beats", wr_n, (int'(v.cnt) << v.sw) >> v.dw);
        chk("R8 burst_end pulses", be_n, v.nb);
        chk("R4 last burst units", last_len, exp_last);
        chk("R6 address/width mismatches", bad_addr, 0);
        chk("R9 single done with busy low", done_n * 10 + bad_misc, 10);
        chk("R9 busy low after done", busy, 0);
        if (v.inj) chk("R1 start while busy ignored, no error", err_cfg, 0);
    endtask

    task automatic try_bad(input string req, input bit exp_cfg, input bit exp_align);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({req, " busy stays low"}, busy, 0);
        chk({req, " err_cfg"}, err_cfg, exp_cfg);
        chk({req, " err_align"}, err_align, exp_align);
        grant = 1'b1;
        @(negedge clk);
        @(negedge clk);
        grant = 1'b0;
        chk({req, " no beats after refusal"}, rd_valid | wr_valid | busy, 0);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset busy", busy, 0);
        chk("R1 reset beats", rd_valid | wr_valid, 0);
        chk("R1 reset pulses", done | burst_end, 0);
        chk("R1 reset errors", err_cfg | err_align, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 grant while idle has no effect
        grant = 1'b1;
        @(negedge clk);
        @(negedge clk);
        grant = 1'b0;
        chk("R8 grant while idle ignored", rd_valid | busy, 0);

        for (int i = 0; i < NV; i++) run_vec(VT[i]);

        // R2 refusal causes
        set_cfg(32'h100, 32'h200, 16'd0, 2'd0, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0);
        try_bad("R2 zero count", 1'b1, 1'b0);
        set_cfg(32'h100, 32'h200, 16'd4, 2'd3, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0);
        try_bad("R2 reserved width", 1'b1, 1'b0);
        set_cfg(32'h100, 32'h200, 16'd4, 2'd1, 2'd0, 2'd1, 1'b1, 1'b1, 1'b1);
        try_bad("R2 byte-only port", 1'b1, 1'b0);
        set_cfg(32'h100, 32'h200, 16'd4, 2'd0, 2'd2, 2'd0, 1'b1, 1'b1, 1'b0);
        try_bad("R2 packing burst", 1'b1, 1'b0);
        set_cfg(32'h100, 32'h200, 16'd6, 2'd0, 2'd2, 2'd1, 1'b1, 1'b1, 1'b0);
        try_bad("R2 packing total", 1'b1, 1'b0);
        // R3 misalignment on each side
        set_cfg(32'h102, 32'h200, 16'd4, 2'd2, 2'd2, 2'd1, 1'b1, 1'b1, 1'b0);
        try_bad("R3 source misaligned", 1'b0, 1'b1);
        set_cfg(32'h100, 32'h201, 16'd4, 2'd1, 2'd1, 2'd1, 1'b1, 1'b1, 1'b0);
        try_bad("R3 destination misaligned", 1'b0, 1'b1);
        // R3 flags clear on the next good start
        run_vec(VT[0]);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule